// File: doc/BRIEF.md
# Serial Character Transmitter with Deferred Stop

This block turns 8-bit characters into an asynchronous serial stream on a single output line. A one-entry holding register takes characters from the write port. Each character is moved into a shift stage when a frame begins, so the next character can be written while the current one is still going out. An external strobe, one clock wide, marks each bit period. Every bit on the line lasts from one strobe to the next.

Three command pulses control the block. Enable lets frames start. Disable stops the block without losing work: if a character is being shifted or is waiting in the holding register, it is sent first. Reset stops the block at once and discards everything. A 3-bit mode input selects the parity bit. Two flags report whether the holding register is free and whether the block as a whole is empty.

Top module: `serial_tx`

## Requirements
- R1: Reset (`rst`) leaves the line high, `hold_empty` = 1, `tx_empty` = 1, and the transmitter disabled.
- R2: A frame is a 0 start bit, then the 8 data bits with bit 0 first, then the optional parity bit, then a 1 stop bit.
- R3: `par_mode` encodes the parity: 0 none, 1 even (total of ones across data and parity is even), 2 odd, 3 forced 0, 4 forced 1. Codes 5 to 7 send no parity bit. The mode is captured when a frame starts.
- R4: A write while the transmitter is disabled is stored: `hold_empty` falls and the line stays high. The character is sent after an enable command, starting at the next baud strobe.
- R5: At a frame start the held character moves to the shift stage and `hold_empty` rises. A character written during a frame goes out immediately after that frame's stop bit.
- R6: A disable command while nothing is held or shifting stops the transmitter at once. A character written afterwards stays held and is not sent.
- R7: A disable command while a character is shifting and another is held lets both frames finish, then stops the transmitter. Later writes are held and not sent.
- R8: A `cmd_reset` pulse aborts any frame. On the next cycle the line is high, the holding register is cleared, and the transmitter is disabled.
- R9: `tx_empty` is 1 only when the holding register is empty and no frame is in progress, including the stop bit.
- R10: The line changes only in the cycle after a baud strobe or a reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit period |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Deferred disable command pulse |
| cmd_reset | input | 1 | Immediate transmitter reset pulse |
| par_mode | input | 3 | Parity selection code |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| tx_line | output | 1 | Serial output line, idles high |
| hold_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding register empty and no frame in progress |

## Verification
A wrong phase or bit count in the shift stage shows up as a garbled frame. The decoder sees it at the sample point of the bad bit, within one baud period of the fault. A wrong enable or pending-disable state shows up as a frame sent when it should not be, or a held character that never leaves. That is visible within one baud period after the next strobe, through the line and `hold_empty`. A holding flag that is stuck or cleared too early disagrees with `hold_empty`/`tx_empty` on the very next cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_SPACE = 3'd3,
        PAR_MARK  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    function automatic logic mode_has_parity(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    function automatic logic parity_value(input logic [2:0] m, input logic ones_odd);
        case (m)
            3'd1:    return ones_odd;
            3'd2:    return ~ones_odd;
            3'd4:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic cmd_enable,
    input  logic cmd_disable,
    input  logic cmd_reset,
    input  logic shift_idle,
    input  logic hold_empty,
    output logic enabled
);
    logic stop_pending;

    always_ff @(posedge clk) begin
        if (rst || cmd_reset) begin
            enabled      <= 1'b0;
            stop_pending <= 1'b0;
        end else if (cmd_enable) begin
            enabled      <= 1'b1;
            stop_pending <= 1'b0;
        end else if ((stop_pending || cmd_disable) && shift_idle && hold_empty) begin
            enabled      <= 1'b0;
            stop_pending <= 1'b0;
        end else if (cmd_disable) begin
            stop_pending <= 1'b1;
        end
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_valid) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              baud_tick,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [2:0]        mode,
    output logic              take,
    output logic              idle,
    output logic              line
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_phase_e         phase;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              pbit;
    logic              with_par;
    logic              can_begin;

    assign can_begin = start_ok && ((phase == PH_IDLE) || (phase == PH_STOP));
    assign take      = baud_tick && can_begin && !abort;
    assign idle      = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            phase    <= PH_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            pbit     <= 1'b0;
            with_par <= 1'b0;
        end else if (baud_tick) begin
            if (can_begin) begin
                shreg    <= hold_data;
                pbit     <= parity_value(mode, ^hold_data);
                with_par <= mode_has_parity(mode);
                bit_cnt  <= '0;
                phase    <= PH_START;
            end else begin
                case (phase)
                    PH_START: begin
                        phase   <= PH_DATA;
                        bit_cnt <= '0;
                    end
                    PH_DATA: begin
                        shreg <= shreg >> 1;
                        if (bit_cnt == LAST_BIT) begin
                            phase <= with_par ? PH_PARITY : PH_STOP;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_PARITY: phase <= PH_STOP;
                    PH_STOP:   phase <= PH_IDLE;
                    default:   phase <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (phase)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg[0];
            PH_PARITY: line = pbit;
            default:   line = 1'b1;
        endcase
    end
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    input  logic [2:0]        par_mode,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_line,
    output logic              hold_empty,
    output logic              tx_empty
);
    logic              enabled;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              shift_idle;

    assign hold_empty = !hold_full;
    assign tx_empty   = shift_idle && !hold_full;

    sertx_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .cmd_reset   (cmd_reset),
        .shift_idle  (shift_idle),
        .hold_empty  (hold_empty),
        .enabled     (enabled)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .clear    (cmd_reset),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .data     (hold_data),
        .full     (hold_full)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .abort     (cmd_reset),
        .baud_tick (baud_tick),
        .start_ok  (enabled && hold_full),
        .hold_data (hold_data),
        .mode      (par_mode),
        .take      (take),
        .idle      (shift_idle),
        .line      (tx_line)
    );
endmodule

// File: rtl/serial_tx_checks.sv
module serial_tx_checks (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic cmd_reset,
    input logic wr_valid,
    input logic tx_line,
    input logic hold_empty,
    input logic tx_empty
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (tx_line && hold_empty && tx_empty));

    a_r8_reset_cmd_stops: assert property (@(posedge clk) disable iff (rst)
        cmd_reset |=> (tx_line && hold_empty && tx_empty));

    a_r4_write_is_held: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !cmd_reset) |=> !hold_empty);

    a_r9_empty_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (tx_line && hold_empty));

    a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !cmd_reset) |=> $stable(tx_line));
endmodule

bind serial_tx serial_tx_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .cmd_reset  (cmd_reset),
    .wr_valid   (wr_valid),
    .tx_line    (tx_line),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/serial_tx_bench.sv
module serial_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cmd_enable = 1'b0;
    logic       cmd_disable = 1'b0;
    logic       cmd_reset = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_line;
    logic       hold_empty;
    logic       tx_empty;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    int tick_cnt = 0;
    logic mon_en = 1'b1;
    logic [10:0] exp_q[$];

    serial_tx u_serial_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .par_mode(par_mode), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_line(tx_line), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tick_cnt  <= (tick_cnt == DIV-1) ? 0 : tick_cnt + 1;
        baud_tick <= (tick_cnt == DIV-1);
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            misses++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // R10: line may change only after a baud strobe or a reset
    logic prev_line = 1'b1, prev_tick = 1'b0, prev_rst = 1'b1;
    always @(negedge clk) begin
        if (tx_line !== prev_line)
            check(prev_tick || prev_rst, "R10", {31'd0, prev_tick}, 32'd1);
        prev_line = tx_line;
        prev_tick = baud_tick;
        prev_rst  = rst || cmd_reset;
    end

    function automatic logic [10:0] frame_bits(input logic [2:0] m, input logic [7:0] d);
        logic p;
        case (m)
            3'd1: p = ^d;
            3'd2: p = ~^d;
            3'd3: p = 1'b0;
            default: p = 1'b1;
        endcase
        if (m >= 3'd1 && m <= 3'd4) return {1'b1, p, d, 1'b0};
        return {1'b0, 1'b1, d, 1'b0};
    endfunction

    // monitor: decodes frames and compares with the scoreboard queue
    initial begin
        logic seen_prev;
        seen_prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && !rst && seen_prev && !tx_line) begin
                logic [10:0] got;
                logic [10:0] exp;
                logic [2:0]  m;
                int nbits;
                got = '0;
                repeat (DIV/2) @(negedge clk);
                got[0] = tx_line;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R7 unexpected frame", 32'd1, 32'd0);
                    nbits = 10;
                    exp = '0;
                end else begin
                    exp = frame_bits(exp_q[0][10:8], exp_q[0][7:0]);
                    m = exp_q[0][10:8];
                    nbits = (m >= 3'd1 && m <= 3'd4) ? 11 : 10;
                end
                for (int i = 1; i < nbits; i++) begin
                    repeat (DIV) @(negedge clk);
                    got[i] = tx_line;
                end
                if (nbits == 10) got[10] = 1'b0;
                if (exp_q.size() != 0) begin
                    void'(exp_q.pop_front());
                    check(got == exp, "R2/R3 frame", {21'd0, got}, {21'd0, exp});
                end
            end
            seen_prev = tx_line;
        end
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d, input logic expect_sent);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        if (expect_sent) exp_q.push_back({par_mode, d});
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (DIV*2) @(negedge clk);
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (tx_line) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1, "R1 line", {31'd0, tx_line}, 32'd1);
        check(hold_empty == 1'b1, "R1 hold_empty", {31'd0, hold_empty}, 32'd1);
        check(tx_empty == 1'b1, "R1 tx_empty", {31'd0, tx_empty}, 32'd1);

        // R4: write while disabled is held
        par_mode = 3'd1;
        write_byte(8'hA5, 1'b1);
        repeat (DIV*4) @(negedge clk);
        check(tx_line == 1'b1, "R4 line idle while disabled", {31'd0, tx_line}, 32'd1);
        check(hold_empty == 1'b0, "R4 byte held", {31'd0, hold_empty}, 32'd0);
        check(tx_empty == 1'b0, "R9 not empty with held byte", {31'd0, tx_empty}, 32'd0);
        pulse(cmd_enable);
        wait_start();
        check(tx_empty == 1'b0, "R9 not empty during frame", {31'd0, tx_empty}, 32'd0);
        wait_drain();
        check(tx_empty == 1'b1, "R9 empty after stop bit", {31'd0, tx_empty}, 32'd1);

        // R2/R3: all parity codes
        for (int m = 2; m <= 6; m++) begin
            par_mode = 3'(m);
            write_byte(8'h3C ^ 8'(m * 17), 1'b1);
            wait_drain();
        end
        par_mode = 3'd2;
        write_byte(8'h00, 1'b1);
        wait_drain();

        // R5: hand-over and back-to-back frames
        par_mode = 3'd1;
        write_byte(8'h01, 1'b1);
        wait_start();
        check(hold_empty == 1'b1, "R5 hold freed at frame start", {31'd0, hold_empty}, 32'd1);
        write_byte(8'hFE, 1'b1);
        check(hold_empty == 1'b0, "R5 next byte held", {31'd0, hold_empty}, 32'd0);
        wait_drain();

        // R6: disable while idle is immediate
        pulse(cmd_disable);
        write_byte(8'h55, 1'b0);
        repeat (DIV*30) @(negedge clk);
        check(hold_empty == 1'b0, "R6 byte not sent after idle disable", {31'd0, hold_empty}, 32'd0);
        check(tx_line == 1'b1, "R6 line idle", {31'd0, tx_line}, 32'd1);
        pulse(cmd_reset);
        @(negedge clk);
        check(hold_empty == 1'b1, "R8 reset clears held byte", {31'd0, hold_empty}, 32'd1);

        // R7: graceful disable drains both registers
        pulse(cmd_enable);
        write_byte(8'h81, 1'b1);
        wait_start();
        write_byte(8'h7E, 1'b1);
        pulse(cmd_disable);
        wait_drain();
        write_byte(8'h99, 1'b0);
        repeat (DIV*30) @(negedge clk);
        check(hold_empty == 1'b0, "R7 stopped after drain", {31'd0, hold_empty}, 32'd0);
        pulse(cmd_reset);

        // R8: reset mid-frame
        mon_en = 1'b0;
        pulse(cmd_enable);
        write_byte(8'hF0, 1'b0);
        wait_start();
        repeat (DIV*2) @(negedge clk);
        write_byte(8'h0F, 1'b0);
        @(negedge clk); cmd_reset = 1'b1;
        @(negedge clk); cmd_reset = 1'b0;
        check(tx_line == 1'b1, "R8 line high after reset", {31'd0, tx_line}, 32'd1);
        check(hold_empty == 1'b1, "R8 hold cleared", {31'd0, hold_empty}, 32'd1);
        check(tx_empty == 1'b1, "R8 tx_empty after reset", {31'd0, tx_empty}, 32'd1);
        write_byte(8'h42, 1'b0);
        repeat (DIV*30) @(negedge clk);
        check(hold_empty == 1'b0, "R8 disabled after reset", {31'd0, hold_empty}, 32'd0);
        check(tx_line == 1'b1, "R8 line stays idle", {31'd0, tx_line}, 32'd1);
        mon_en = 1'b1;

        repeat (DIV) @(negedge clk);
        finish_run();
    end
endmodule